// File: doc/BRIEF.md
# DMA Transfer Bus-Cycle Sequencer

This block moves one DMA transfer unit, 8 or 16 bits wide, by first reading it from a source address and then writing it to a destination address over a simple bus master port. Each of the two phases is broken into as many bus cycles as the unit needs. The count depends on the unit size, on whether the bus is 8 or 16 bits wide, on the alignment of that phase's address, and on whether the address falls in a slow region that needs a wait clock. The bytes that are read are gathered in an internal 16-bit holding register, and the write phase drives them out again.

A requester pulses `start_i` with the two addresses and the unit size. The block returns a one-clock `done_o` and reports in `cycles_o` how many bus clocks the transfer took. Two inclusive address windows, supplied as static inputs, mark the register-space region and the wait region. Both windows cost one extra clock per bus cycle. Each bus cycle lasts one clock, or two clocks in a slow region. The strobe is level-driven, and read data is sampled on the final clock of the cycle.

Top module: `dma_bus_seq`

## Requirements
- R1: The read phase finishes all of its bus cycles before any write cycle starts. The first write clock comes in the clock right after the last read clock.
- R2: An 8-bit unit takes exactly one bus cycle per phase. On a 16-bit bus, a byte at an even address uses lanes [7:0] with byte enable 2'b01, and a byte at an odd address uses lanes [15:8] with 2'b10.
- R3: A 16-bit unit on a 16-bit bus at an even address takes one bus cycle with byte enable 2'b11. The unit's low byte travels on [7:0].
- R4: A 16-bit unit on a 16-bit bus at an odd address takes two bus cycles. The first is at the odd address with enable 2'b10 and carries the low byte on [15:8]. The second is at the address plus one with enable 2'b01 and carries the high byte on [7:0].
- R5: With `bus8_i`=1, a 16-bit unit is moved as two bus cycles per phase, at the address and then the address plus one. Both use enable 2'b01 with data on [7:0], low byte first. This holds in every region, including the register-space window.
- R6: A bus cycle whose address lies inside either inclusive window [`regs_lo_i`,`regs_hi_i`] or [`wait_lo_i`,`wait_hi_i`] holds its strobe, address and enables for two clocks instead of one.
- R7: The split and wait rules are applied to the read phase and the write phase separately, each using that phase's own address of each bus cycle.
- R8: `bus_rd_o` and `bus_wr_o` are never high together, and both are low whenever `busy_o` is low.
- R9: `done_o` is high for exactly one clock, the clock after the final write clock, and `busy_o` is low in that clock. `cycles_o` then equals the number of clocks during which a strobe was high for that transfer.
- R10: A `start_i` seen while idle makes the first read strobe appear in the next clock. A `start_i` seen while busy is ignored and changes no bus cycle.
- R11: After reset the block is idle, with no strobe, `done_o` low and `cycles_o` zero.
- R12: The data driven on the enabled write lanes equals the bytes that were read, in the same byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one transfer unit (taken only when idle) |
| src_addr_i | input | AW | Source byte address |
| dst_addr_i | input | AW | Destination byte address |
| unit16_i | input | 1 | 1: 16-bit unit, 0: 8-bit unit |
| bus8_i | input | 1 | 1: 8-bit bus, 0: 16-bit bus |
| regs_lo_i | input | AW | Register-space window low bound (inclusive) |
| regs_hi_i | input | AW | Register-space window high bound (inclusive) |
| wait_lo_i | input | AW | Wait window low bound (inclusive) |
| wait_hi_i | input | AW | Wait window high bound (inclusive) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock completion pulse |
| cycles_o | output | CW | Bus clocks used by the last transfer |
| bus_addr_o | output | AW | Bus address |
| bus_be_o | output | 2 | Byte enables, bit 0 = lanes [7:0] |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_rdata_i | input | 16 | Read data |
| bus_wdata_o | output | 16 | Write data |

## Verification
Some properties are checked on every clock. These are the mutual exclusion of the strobes, the one-clock width of `done_o`, the handover from the last read clock directly to a write clock, the two-clock hold of a slow bus cycle, the 2'b01-only enables on an 8-bit bus, and that enable 2'b10 appears only at odd addresses. The exact sequence of addresses, enables and write data for each mix of alignment, width and region can only be shown by the bench's scenarios. The same applies to the reported clock count, to window edges that split one unit across a slow and a fast bus cycle, and to a start that arrives in mid-transfer being ignored.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;

  // A 16-bit unit needs two bus cycles on a narrow bus or at an odd address.
  function automatic logic unit_split(input logic u16, input logic b8, input logic a0);
    return u16 && (b8 || a0);
  endfunction

  // Byte-enable for one bus cycle.
  function automatic logic [1:0] cyc_be(input logic full, input logic b8, input logic a0);
    if (full)
      return 2'b11;
    else if (!b8 && a0)
      return 2'b10;
    else
      return 2'b01;
  endfunction

  // Inclusive window hit.
  function automatic logic win_hit(input logic [31:0] a, input logic [31:0] lo,
                                   input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/dma_seq_region.sv
module dma_seq_region #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] regs_lo_i,
  input  logic [AW-1:0] regs_hi_i,
  input  logic [AW-1:0] wait_lo_i,
  input  logic [AW-1:0] wait_hi_i,
  output logic          slow_o
);
  import dma_seq_pkg::*;

  localparam int NWIN = 2;

  logic [AW-1:0] lo_w [NWIN];
  logic [AW-1:0] hi_w [NWIN];
  logic [NWIN-1:0] hit;

  assign lo_w[0] = regs_lo_i;
  assign hi_w[0] = regs_hi_i;
  assign lo_w[1] = wait_lo_i;
  assign hi_w[1] = wait_hi_i;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = win_hit(32'(addr_i), 32'(lo_w[w]), 32'(hi_w[w]));
  end

  assign slow_o = |hit;

endmodule

// File: rtl/dma_seq_piece.sv
module dma_seq_piece #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic          u16_i,
  input  logic          b8_i,
  input  logic          idx_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    be_o,
  output logic          full_o,
  output logic          lane_hi_o,
  output logic          last_o
);
  import dma_seq_pkg::*;

  logic split;

  assign split     = unit_split(u16_i, b8_i, base_i[0]);
  assign full_o    = u16_i && !split;
  assign addr_o    = base_i + AW'(split && idx_i);
  assign lane_hi_o = !b8_i && addr_o[0];
  assign be_o      = cyc_be(full_o, b8_i, addr_o[0]);
  assign last_o    = !split || idx_i;

endmodule

// File: rtl/dma_seq_hold.sv
module dma_seq_hold (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_i,
  input  logic        full_i,
  input  logic        idx_i,
  input  logic        lane_hi_i,
  input  logic [15:0] rdata_i,
  output logic [15:0] wdata_o
);
  logic [15:0] hold_q;
  logic [7:0]  rd_byte;
  logic [7:0]  wr_byte;

  assign rd_byte = lane_hi_i ? rdata_i[15:8] : rdata_i[7:0];
  assign wr_byte = idx_i ? hold_q[15:8] : hold_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_i) begin
      if (full_i)
        hold_q <= rdata_i;
      else if (idx_i)
        hold_q[15:8] <= rd_byte;
      else
        hold_q[7:0] <= rd_byte;
    end
  end

  always_comb begin
    if (full_i)
      wdata_o = hold_q;
    else if (lane_hi_i)
      wdata_o = {wr_byte, 8'h00};
    else
      wdata_o = {8'h00, wr_byte};
  end

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq #(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          unit16_i,
  input  logic          bus8_i,
  input  logic [AW-1:0] regs_lo_i,
  input  logic [AW-1:0] regs_hi_i,
  input  logic [AW-1:0] wait_lo_i,
  input  logic [AW-1:0] wait_hi_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] cycles_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_be_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  input  logic [15:0]   bus_rdata_i,
  output logic [15:0]   bus_wdata_o
);
  import dma_seq_pkg::*;

  seq_st_e       state_q;
  logic          idx_q;
  logic          wsub_q;
  logic [AW-1:0] src_q;
  logic [AW-1:0] dst_q;
  logic          u16_q;
  logic          b8_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cycles_q;
  logic          done_q;

  // named internal events
  logic          strobe;
  logic          slow;
  logic          cyc_end;
  logic          phase_end;
  logic          cap_en;
  logic [AW-1:0] cur_base;
  logic [AW-1:0] pm_addr;
  logic [1:0]    pm_be;
  logic          pm_full;
  logic          pm_lane_hi;
  logic          pm_last;

  assign strobe    = (state_q != ST_IDLE);
  assign cur_base  = (state_q == ST_WR) ? dst_q : src_q;
  assign cyc_end   = strobe && (!slow || wsub_q);
  assign phase_end = cyc_end && pm_last;
  assign cap_en    = (state_q == ST_RD) && cyc_end;

  dma_seq_piece #(.AW(AW)) u_piece (
    .base_i   (cur_base),
    .u16_i    (u16_q),
    .b8_i     (b8_q),
    .idx_i    (idx_q),
    .addr_o   (pm_addr),
    .be_o     (pm_be),
    .full_o   (pm_full),
    .lane_hi_o(pm_lane_hi),
    .last_o   (pm_last)
  );

  dma_seq_region #(.AW(AW)) u_region (
    .addr_i   (pm_addr),
    .regs_lo_i(regs_lo_i),
    .regs_hi_i(regs_hi_i),
    .wait_lo_i(wait_lo_i),
    .wait_hi_i(wait_hi_i),
    .slow_o   (slow)
  );

  dma_seq_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_i    (cap_en),
    .full_i   (pm_full),
    .idx_i    (idx_q),
    .lane_hi_i(pm_lane_hi),
    .rdata_i  (bus_rdata_i),
    .wdata_o  (bus_wdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= 1'b0;
      wsub_q   <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      u16_q    <= 1'b0;
      b8_q     <= 1'b0;
      cnt_q    <= '0;
      cycles_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          src_q   <= src_addr_i;
          dst_q   <= dst_addr_i;
          u16_q   <= unit16_i;
          b8_q    <= bus8_i;
          idx_q   <= 1'b0;
          wsub_q  <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_RD;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cyc_end) begin
          wsub_q <= 1'b0;
          if (phase_end) begin
            idx_q <= 1'b0;
            if (state_q == ST_RD) begin
              state_q <= ST_WR;
            end else begin
              state_q  <= ST_IDLE;
              done_q   <= 1'b1;
              cycles_q <= cnt_q + 1'b1;
            end
          end else begin
            idx_q <= 1'b1;
          end
        end else begin
          wsub_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o     = strobe;
  assign done_o     = done_q;
  assign cycles_o   = cycles_q;
  assign bus_addr_o = strobe ? pm_addr : '0;
  assign bus_be_o   = strobe ? pm_be : 2'b00;
  assign bus_rd_o   = (state_q == ST_RD);
  assign bus_wr_o   = (state_q == ST_WR);

  assert_rw_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_rd_to_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd_o) && !bus_rd_o) |-> bus_wr_o);

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && slow && !wsub_q) |=>
      ($stable(bus_addr_o) && $stable(bus_be_o) && $stable(bus_rd_o) && $stable(bus_wr_o)));

  assert_narrow_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd_o || bus_wr_o) && b8_q) |-> (bus_be_o == 2'b01));

  assert_upper_lane_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_be_o == 2'b10) |-> bus_addr_o[0]);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(src_q) && $stable(dst_q)));

endmodule

// File: tb/dma_bus_seq_tb.sv
module dma_bus_seq_tb;
  localparam int AW = 16;
  localparam int CW = 4;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [1:0]    be;
    logic          rd;
    logic          wr;
    logic [15:0]   data;
  } bus_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] src = '0, dst = '0;
  logic u16 = 1'b0, b8 = 1'b0;
  logic [AW-1:0] regs_lo = 16'h0300, regs_hi = 16'h03FF;
  logic [AW-1:0] wait_lo = 16'h8000, wait_hi = 16'h80FF;
  logic busy, done, rd, wr;
  logic [CW-1:0] cycles;
  logic [AW-1:0] baddr;
  logic [1:0] be;
  logic [15:0] rdata, wdata;

  int total = 0;
  int bad = 0;
  bus_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_bus_seq #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .src_addr_i(src), .dst_addr_i(dst),
    .unit16_i(u16), .bus8_i(b8), .regs_lo_i(regs_lo), .regs_hi_i(regs_hi),
    .wait_lo_i(wait_lo), .wait_hi_i(wait_hi), .busy_o(busy), .done_o(done),
    .cycles_o(cycles), .bus_addr_o(baddr), .bus_be_o(be), .bus_rd_o(rd),
    .bus_wr_o(wr), .bus_rdata_i(rdata), .bus_wdata_o(wdata)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // memory model: even byte on [7:0], odd on [15:8]; narrow bus uses [7:0]
  always_comb begin
    if (b8) rdata = {8'h00, mem_byte(baddr)};
    else    rdata = {mem_byte(baddr | 16'h1), mem_byte(baddr & ~16'h1)};
  end

  function automatic logic is_slow(input logic [AW-1:0] a);
    return (a >= regs_lo && a <= regs_hi) || (a >= wait_lo && a <= wait_hi);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected bus clocks for one phase
  task automatic push_phase(input logic [AW-1:0] base, input logic is_wr,
                            input logic [7:0] b0, input logic [7:0] b1, inout int n);
    int pieces;
    pieces = (u16 && (b8 || base[0])) ? 2 : 1;
    for (int k = 0; k < pieces; k++) begin
      bus_item_t it;
      logic [7:0] byt;
      it.addr = base + AW'(pieces == 2 ? k : 0);
      it.rd = !is_wr;
      it.wr = is_wr;
      byt = (k == 0) ? b0 : b1;
      if (u16 && pieces == 1) begin
        it.be = 2'b11;
        it.data = {b1, b0};
      end else if (!b8 && it.addr[0]) begin
        it.be = 2'b10;
        it.data = {byt, 8'h00};
      end else begin
        it.be = 2'b01;
        it.data = {8'h00, byt};
      end
      exp_q.push_back(it);
      n++;
      if (is_slow(it.addr)) begin
        exp_q.push_back(it);
        n++;
      end
    end
  endtask

  // monitor: compare every strobed clock against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (rd || wr)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected strobe addr", 32'(baddr), 32'hFFFF_FFFF);
      end else begin
        bus_item_t e;
        logic [15:0] m;
        e = exp_q.pop_front();
        check(baddr == e.addr, "R7", "bus addr", 32'(baddr), 32'(e.addr));
        check(be == e.be, "R2/R3/R4/R5", "byte enable", 32'(be), 32'(e.be));
        check(rd == e.rd && wr == e.wr, "R1", "strobe rd,wr", {rd, wr}, {e.rd, e.wr});
        if (e.wr) begin
          m = {{8{e.be[1]}}, {8{e.be[0]}}};
          check((wdata & m) == (e.data & m), "R12", "write data",
                32'(wdata & m), 32'(e.data & m));
        end
      end
    end
  end

  task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] d,
                     input logic w16, input logic n8, input logic poke, input string tag);
    int n;
    logic [7:0] b0, b1;
    n = 0;
    @(negedge clk);
    src = s; dst = d; u16 = w16; b8 = n8;
    b0 = mem_byte(s);
    b1 = mem_byte(s + 16'h1);
    push_phase(s, 1'b0, b0, b1, n);
    push_phase(d, 1'b1, b0, b1, n);
    start = 1'b1;
    @(negedge clk);
    check(rd == 1'b1, "R10", {tag, " read strobe after start"}, 32'(rd), 32'h1);
    if (poke) begin
      src = s ^ 16'h0F0F; dst = d ^ 16'h00F0;
      @(negedge clk);
    end
    start = 1'b0;
    src = s; dst = d;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    check(done == 1'b1, "R9", {tag, " done seen"}, 32'(done), 32'h1);
    check(busy == 1'b0, "R9", {tag, " busy low with done"}, 32'(busy), 32'h0);
    check(cycles == CW'(n), "R9", {tag, " cycle count"}, 32'(cycles), 32'(n));
    check(exp_q.size() == 0, "R1", {tag, " all bus cycles seen"}, 32'(exp_q.size()), 32'h0);
    exp_q.delete();
    @(negedge clk);
    check(done == 1'b0, "R9", {tag, " done one clock"}, 32'(done), 32'h0);
    check(!rd && !wr, "R8", {tag, " idle strobes"}, {rd, wr}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd && !wr, "R11", "reset idle", {busy, done, rd, wr}, 32'h0);
    check(cycles == '0, "R11", "reset cycles", 32'(cycles), 32'h0);
    rst_n = 1'b1;
    // R2: byte units, wide and narrow bus, both alignments
    run(16'h0010, 16'h0021, 1'b0, 1'b0, 1'b0, "R2 byte even->odd");
    run(16'h0033, 16'h0040, 1'b0, 1'b0, 1'b0, "R2 byte odd->even");
    run(16'h0035, 16'h0047, 1'b0, 1'b1, 1'b0, "R2 byte narrow bus");
    // R3: aligned word
    run(16'h0100, 16'h0202, 1'b1, 1'b0, 1'b0, "R3 word aligned");
    // R4: odd/odd and odd/even words
    run(16'h0101, 16'h0203, 1'b1, 1'b0, 1'b0, "R4 word odd/odd");
    run(16'h0105, 16'h0208, 1'b1, 1'b0, 1'b0, "R4 word odd/even");
    // R5: narrow bus word, also into the register window
    run(16'h0120, 16'h0310, 1'b1, 1'b1, 1'b0, "R5 narrow word");
    // R6/R7: slow read region, slow odd write region
    run(16'h0302, 16'h8011, 1'b1, 1'b0, 1'b0, "R6 slow both");
    // R7: window edges split a unit between slow and fast cycles
    run(16'h02FF, 16'h03FF, 1'b1, 1'b0, 1'b0, "R7 window edges");
    run(16'h80FF, 16'h7FFF, 1'b1, 1'b1, 1'b0, "R7 narrow edges");
    // R10: start pulses in mid-transfer are ignored
    run(16'h0501, 16'h8003, 1'b1, 1'b0, 1'b1, "R10 start while busy");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule